// File: doc/BRIEF.md
# Quantum Operation Issue Front End

This block sits between an instruction fetch path and two playback queues of a qubit control pipeline. It takes one 32-bit microinstruction at a time over a valid/ready handshake and turns it into queue entries. It does not execute operations. It builds a timeline instead. A wait instruction closes the current timing point: it pushes an entry holding its interval and a freshly advanced label to the timing queue. Every pulse, measurement-pulse or discrimination instruction that follows becomes an event entry tagged with that label. A later stage replays the timeline with fixed timing and fires each event when its label comes up.

The front end runs as fast as its inputs and the queues allow, and it has no timing guarantees of its own. When either queue reports full, the instruction is held and nothing is pushed. A pulse instruction can carry two (qubit mask, micro-operation) pairs. It issues one event per cycle, and the instruction is consumed together with its last event. Opcodes outside the four defined kinds are discarded and leave a sticky error flag.

Instruction word layout: bits [31:28] opcode (0 wait, 1 pulse, 2 measurement pulse, 3 discriminate, 4 to 15 illegal). Bits [27:20] are the first qubit mask and bits [19:16] the first micro-operation or register index. Bits [15:0] hold the interval or the duration. For a pulse, the second pair is a mask in bits [11:4] and a micro-operation in bits [3:0].

Top module: `qop_issue`

## Requirements
- R1: After reset the current label (`ev_label`) is 0, `err_flag` is 0, and with `in_valid` low neither push output is asserted.
- R2: A wait (opcode 0) is consumed in the cycle it is presented with both queues not full. In that cycle `tp_push` is 1, `tp_interval` equals word[15:0] and `tp_label` equals the current label plus one.
- R3: The current label advances by one, modulo 2^LBL_W, on each consumed wait and on nothing else. Every event pushed carries the current label on `ev_label`.
- R4: A pulse (opcode 1) pushes one event of kind 1 for each pair whose mask is nonzero: the first pair, then the second pair in the next cycle, with `ev_mask` set to the mask, `ev_arg` to the micro-operation and `ev_dur` 0. `in_ready` is high only in the cycle of the last event.
- R5: A pulse whose two masks are both zero is consumed in one cycle and pushes nothing.
- R6: A measurement pulse (opcode 2) pushes one event of kind 2 with the mask from word[27:20], `ev_arg` 0 and `ev_dur` equal to word[15:0].
- R7: A discrimination (opcode 3) pushes one event of kind 3 with the mask from word[27:20], `ev_arg` equal to the register index word[19:16] and `ev_dur` 0.
- R8: While `tq_full` or `eq_full` is high, `in_ready`, `tp_push` and `ev_push` are all 0, and the held instruction is not altered.
- R9: An illegal opcode (4 to 15) is consumed without any push. `err_flag` is 1 from the next cycle and stays 1 until reset.
- R10: `tp_push` and `ev_push` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is valid |
| in_word | input | 32 | Microinstruction |
| in_ready | output | 1 | Instruction consumed this cycle when valid |
| tq_full | input | 1 | Timing queue cannot accept an entry |
| tp_push | output | 1 | Push to timing queue |
| tp_interval | output | 16 | Interval in cycles to the new timing point |
| tp_label | output | LBL_W | Label of the new timing point |
| eq_full | input | 1 | Event queue cannot accept an entry |
| ev_push | output | 1 | Push to event queue |
| ev_kind | output | 2 | Event kind: 1 pulse, 2 measurement pulse, 3 discriminate |
| ev_label | output | LBL_W | Current label, carried by each event |
| ev_mask | output | 8 | Qubit address mask |
| ev_arg | output | 4 | Micro-operation or destination register |
| ev_dur | output | 16 | Measurement pulse duration |
| err_flag | output | 1 | Sticky illegal-opcode flag |

## Verification
The push outputs, their fields and `in_ready` are combinational from the presented word and the full inputs, so they are due in the same cycle the stimulus is driven. The label and `err_flag` change only at the clock edge that consumes an instruction, and the second event of a two-pair pulse appears one cycle after the first. The bench drives on the falling edge and samples shortly after it. It compares against a cycle model whose label, pair phase and error state it updates only at the following rising edge, so each sample sees the results of earlier edges only.

// File: rtl/qop_pkg.sv
package qop_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 4;
  localparam int MASK_W = 8;
  localparam int FLD_W  = 4;
  localparam int IMM_W  = 16;
  localparam int KIND_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_WAIT  = 4'd0,
    OP_PULSE = 4'd1,
    OP_MEAS  = 4'd2,
    OP_DISC  = 4'd3
  } op_e;

  function automatic logic [OPC_W-1:0] w_opc(input logic [WORD_W-1:0] w);
    return w[31:28];
  endfunction

  function automatic logic [MASK_W-1:0] w_mask_a(input logic [WORD_W-1:0] w);
    return w[27:20];
  endfunction

  function automatic logic [FLD_W-1:0] w_fld_a(input logic [WORD_W-1:0] w);
    return w[19:16];
  endfunction

  function automatic logic [MASK_W-1:0] w_mask_b(input logic [WORD_W-1:0] w);
    return w[11:4];
  endfunction

  function automatic logic [FLD_W-1:0] w_fld_b(input logic [WORD_W-1:0] w);
    return w[3:0];
  endfunction

  function automatic logic [IMM_W-1:0] w_imm(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction
endpackage

// File: rtl/qop_decode.sv
module qop_decode
  import qop_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              half_done,
  output logic              is_wait,
  output logic              is_bad,
  output logic              ev_need,
  output logic              last_piece,
  output logic [KIND_W-1:0] kind,
  output logic [MASK_W-1:0] mask,
  output logic [FLD_W-1:0]  arg,
  output logic [IMM_W-1:0]  dur,
  output logic [IMM_W-1:0]  imm
);
  logic [OPC_W-1:0] opc;
  logic             pa_live, pb_live;

  always_comb begin
    opc     = w_opc(word);
    imm     = w_imm(word);
    kind    = opc[KIND_W-1:0];
    pa_live = (w_mask_a(word) != '0) && !half_done;
    pb_live = (w_mask_b(word) != '0);
    is_wait = (opc == OP_WAIT);
    is_bad  = (opc > OP_DISC);
    ev_need    = 1'b0;
    last_piece = 1'b1;
    mask = '0;
    arg  = '0;
    dur  = '0;
    case (opc)
      OP_PULSE: begin
        ev_need    = pa_live || pb_live;
        last_piece = !(pa_live && pb_live);
        mask       = pa_live ? w_mask_a(word) : w_mask_b(word);
        arg        = pa_live ? w_fld_a(word)  : w_fld_b(word);
      end
      OP_MEAS: begin
        ev_need = 1'b1;
        mask    = w_mask_a(word);
        dur     = imm;
      end
      OP_DISC: begin
        ev_need = 1'b1;
        mask    = w_mask_a(word);
        arg     = w_fld_a(word);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qop_label_ctr.sv
module qop_label_ctr #(
  parameter int LBL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [LBL_W-1:0] label,
  output logic [LBL_W-1:0] label_nxt
);
  assign label_nxt = label + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    label <= '0;
    else if (bump) label <= label_nxt;
  end
endmodule

// File: rtl/qop_pair_seq.sv
module qop_pair_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic last_piece,
  output logic half_done
);
  always_ff @(posedge clk) begin
    if (!rst_n)   half_done <= 1'b0;
    else if (adv) half_done <= !last_piece;
  end
endmodule

// File: rtl/qop_issue.sv
module qop_issue
  import qop_pkg::*;
#(
  parameter int LBL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              tq_full,
  output logic              tp_push,
  output logic [IMM_W-1:0]  tp_interval,
  output logic [LBL_W-1:0]  tp_label,
  input  logic              eq_full,
  output logic              ev_push,
  output logic [KIND_W-1:0] ev_kind,
  output logic [LBL_W-1:0]  ev_label,
  output logic [MASK_W-1:0] ev_mask,
  output logic [FLD_W-1:0]  ev_arg,
  output logic [IMM_W-1:0]  ev_dur,
  output logic              err_flag
);
  logic space_ok, go, half_done;
  logic is_wait, is_bad, ev_need, last_piece;
  logic bad_taken;

  assign space_ok = !tq_full && !eq_full;
  assign go       = in_valid && space_ok;

  qop_decode u_dec (
    .word       (in_word),
    .half_done  (half_done),
    .is_wait    (is_wait),
    .is_bad     (is_bad),
    .ev_need    (ev_need),
    .last_piece (last_piece),
    .kind       (ev_kind),
    .mask       (ev_mask),
    .arg        (ev_arg),
    .dur        (ev_dur),
    .imm        (tp_interval)
  );

  qop_label_ctr #(.LBL_W(LBL_W)) u_lbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bump      (tp_push),
    .label     (ev_label),
    .label_nxt (tp_label)
  );

  qop_pair_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (ev_push),
    .last_piece (last_piece),
    .half_done  (half_done)
  );

  assign tp_push   = go && is_wait;
  assign ev_push   = go && ev_need;
  assign in_ready  = space_ok && (!ev_need || last_piece);
  assign bad_taken = go && is_bad;

  always_ff @(posedge clk) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (bad_taken) err_flag <= 1'b1;
  end
endmodule

// File: rtl/qop_issue_chk.sv
module qop_issue_chk #(
  parameter int LBL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      in_word,
  input logic             in_ready,
  input logic             tq_full,
  input logic             eq_full,
  input logic             tp_push,
  input logic             ev_push,
  input logic [LBL_W-1:0] tp_label,
  input logic [LBL_W-1:0] ev_label,
  input logic             err_flag,
  input logic             half_done
);
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_full || eq_full) |-> (!in_ready && !tp_push && !ev_push)); // R8
  AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(tp_push && ev_push)); // R10
  AST_LABEL_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    tp_push |-> (tp_label == LBL_W'(ev_label + 1'b1))); // R2
  AST_LABEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tp_push |=> (ev_label == $past(tp_label))); // R3
  AST_LABEL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_push |=> $stable(ev_label)); // R3
  AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[31:28] > 4'd3) |=> err_flag); // R9
  AST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_SECOND_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !in_ready) |=> half_done); // R4
endmodule

bind qop_issue qop_issue_chk #(.LBL_W(LBL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .in_ready(in_ready), .tq_full(tq_full), .eq_full(eq_full),
  .tp_push(tp_push), .ev_push(ev_push), .tp_label(tp_label),
  .ev_label(ev_label), .err_flag(err_flag), .half_done(half_done)
);

// File: tb/qop_issue_bench.sv
module qop_issue_bench;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic tq_full = 1'b0, eq_full = 1'b0;
  logic in_ready, tp_push, ev_push, err_flag;
  logic [15:0] tp_interval, ev_dur;
  logic [LW-1:0] tp_label, ev_label;
  logic [1:0] ev_kind;
  logic [7:0] ev_mask;
  logic [3:0] ev_arg;

  int checks = 0, errors = 0, cycles = 0;
  logic [LW-1:0] m_lbl = '0;
  bit m_half = 0, m_err = 0;

  always #10 clk = ~clk;

  qop_issue #(.LBL_W(LW)) u_qop_issue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .tq_full(tq_full), .tp_push(tp_push),
    .tp_interval(tp_interval), .tp_label(tp_label), .eq_full(eq_full),
    .ev_push(ev_push), .ev_kind(ev_kind), .ev_label(ev_label),
    .ev_mask(ev_mask), .ev_arg(ev_arg), .ev_dur(ev_dur), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [7:0] ma, input logic [3:0] fa,
                                     input logic [7:0] mb, input logic [3:0] fb);
    return {op, ma, fa, 4'h0, mb, fb};
  endfunction

  function automatic logic [31:0] mk_imm(input logic [3:0] op, input logic [7:0] ma,
                                         input logic [3:0] fa, input logic [15:0] v);
    return {op, ma, fa, v};
  endfunction

  task automatic cyc(input bit v, input logic [31:0] w, input bit tqf, input bit eqf, output bit acc);
    logic [3:0] op;
    bit full, pa, pb, need, last, e_rdy, e_tp, e_ev;
    logic [7:0] e_mask;
    logic [3:0] e_arg;
    logic [15:0] e_dur;
    string tag;
    @(negedge clk);
    in_valid = v; in_word = w; tq_full = tqf; eq_full = eqf;
    #2;
    op = w[31:28];
    full = tqf || eqf;
    pa = (w[27:20] != 0) && !m_half;
    pb = (w[11:4] != 0);
    need = 0; last = 1; e_mask = 0; e_arg = 0; e_dur = 0;
    if (op == 1) begin
      need = pa || pb; last = !(pa && pb);
      e_mask = pa ? w[27:20] : w[11:4];
      e_arg  = pa ? w[19:16] : w[3:0];
    end else if (op == 2) begin
      need = 1; e_mask = w[27:20]; e_dur = w[15:0];
    end else if (op == 3) begin
      need = 1; e_mask = w[27:20]; e_arg = w[19:16];
    end
    e_rdy = !full && (!need || last);
    e_tp  = v && !full && op == 0;
    e_ev  = v && !full && need;
    if (full) tag = "R8";
    else if (op == 0) tag = "R2";
    else if (op == 1) tag = need ? "R4" : "R5";
    else if (op == 2) tag = "R6";
    else if (op == 3) tag = "R7";
    else tag = "R9";
    chk({in_ready, tp_push, ev_push} == {e_rdy, e_tp, e_ev}, tag,
        {in_ready, tp_push, ev_push}, {e_rdy, e_tp, e_ev});
    if (e_tp)
      chk({tp_interval, tp_label} == {w[15:0], LW'(m_lbl + 1)}, "R2",
          {tp_interval, tp_label}, {w[15:0], LW'(m_lbl + 1)});
    if (e_ev)
      chk({ev_kind, ev_mask, ev_arg, ev_dur} == {op[1:0], e_mask, e_arg, e_dur}, tag,
          {ev_kind, ev_mask, ev_arg, ev_dur}, {op[1:0], e_mask, e_arg, e_dur});
    chk(ev_label == m_lbl, "R3", ev_label, m_lbl);
    chk(err_flag == m_err, "R9", err_flag, m_err);
    chk(!(tp_push && ev_push), "R10", {tp_push, ev_push}, 2'b00);
    acc = v && e_rdy;
    @(posedge clk);
    cycles++;
    if (v && !full) begin
      if (op == 0) m_lbl = m_lbl + 1;
      if (need) m_half = !last;
      if (op > 3) m_err = 1;
    end
  endtask

  task automatic issue(input logic [31:0] w, input int stall_pct);
    bit acc = 0;
    while (!acc) begin
      bit tqf = ($urandom % 100) < stall_pct;
      bit eqf = ($urandom % 100) < stall_pct;
      cyc(1, w, tqf, eqf, acc);
    end
  endtask

  function automatic logic [31:0] rnd_word();
    int k = $urandom % 9;
    logic [3:0] op;
    logic [7:0] ma, mb;
    if (k < 2) op = 0; else if (k < 5) op = 1; else if (k == 5) op = 2;
    else if (k == 6) op = 3; else if (k == 7) op = 4'(4 + $urandom % 12); else op = 1;
    ma = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
    mb = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
    if (op == 1) return mk(op, ma, 4'($urandom), mb, 4'($urandom));
    return mk_imm(op, ma, 4'($urandom), 16'($urandom));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'h51C0_0A7E));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: state after reset, no valid input
    #2;
    chk(ev_label == 0, "R1", ev_label, 0);
    chk(err_flag == 0, "R1", err_flag, 0);
    chk(!tp_push && !ev_push, "R1", {tp_push, ev_push}, 0);
    cyc(0, 32'h1000_0000, 0, 0, acc);
    // directed: wait, two-pair pulse, second-pair-only pulse, empty pulse
    issue(mk_imm(4'd0, 8'h00, 4'h0, 16'd37), 0);
    issue(mk(4'd1, 8'h05, 4'h3, 8'hA0, 4'h9), 0);        // R4 two events
    issue(mk(4'd1, 8'h00, 4'h3, 8'h11, 4'h6), 0);        // R4 second pair only
    issue(mk(4'd1, 8'h00, 4'h7, 8'h00, 4'h2), 0);        // R5 nothing pushed
    issue(mk_imm(4'd2, 8'hC3, 4'h0, 16'hFFFF), 0);       // R6
    issue(mk_imm(4'd3, 8'h81, 4'hE, 16'h1234), 0);       // R7
    // R8: full on each queue holds a measurement and a pulse mid-pair
    cyc(1, mk_imm(4'd2, 8'h0F, 4'h0, 16'd9), 1, 0, acc);
    cyc(1, mk_imm(4'd2, 8'h0F, 4'h0, 16'd9), 0, 1, acc);
    issue(mk_imm(4'd2, 8'h0F, 4'h0, 16'd9), 0);
    cyc(1, mk(4'd1, 8'h02, 4'h1, 8'h40, 4'h8), 0, 0, acc);
    cyc(1, mk(4'd1, 8'h02, 4'h1, 8'h40, 4'h8), 0, 1, acc);
    issue(mk(4'd1, 8'h02, 4'h1, 8'h40, 4'h8), 0);
    cyc(1, mk_imm(4'd0, 8'h00, 4'h0, 16'd5), 1, 1, acc);
    issue(mk_imm(4'd0, 8'h00, 4'h0, 16'd5), 0);
    // R9: illegal opcode then normal traffic keeps flag
    issue(mk_imm(4'd9, 8'hFF, 4'hF, 16'hBEEF), 0);
    issue(mk_imm(4'd3, 8'h01, 4'h2, 16'h0), 0);
    // R3 wrap of label
    for (int i = 0; i < 260; i++) issue(mk_imm(4'd0, 8'h00, 4'h0, 16'(i)), 0);
    issue(mk(4'd1, 8'h10, 4'h4, 8'h00, 4'h0), 0);
    // reset clears flag and label (R1)
    @(negedge clk); rst_n = 1'b0; in_valid = 0;
    @(posedge clk); cycles++;
    @(negedge clk); rst_n = 1'b1;
    m_lbl = '0; m_half = 0; m_err = 0;
    #2;
    chk(ev_label == 0 && err_flag == 0, "R1", {ev_label, err_flag}, 0);
    // random traffic with random back-pressure
    for (int i = 0; i < 1500; i++) issue(rnd_word(), 25);
    cyc(0, 32'h0, 0, 0, acc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule